// File: doc/BRIEF.md
# Key Matrix Scanner with Boot Keyboard Report

This block scans a grid of key switches, 8 rows by 18 columns, and turns the set of pressed keys into the 8-byte input report of the HID keyboard boot protocol. The columns idle high through pull-ups. Once per scan period the block pulls one row low at a time. It waits a configurable number of clocks for the lines to settle and then samples the 18 columns, where a low column means a closed switch on the driven row. Sampling only once per period also serves as the debounce.

After the last row has been sampled, the block looks at the whole snapshot. A pattern where three pressed keys sit on three corners of a rectangle cannot be told apart from a phantom fourth key, so that scan is discarded. Otherwise, if the set of pressed keys differs from the last accepted set, a fresh report is built and flagged to the consumer. The report holds a modifier byte, a zero byte and six key slots. The consumer clears the flag with an acknowledge, and a later scan result replaces a report that has not yet been taken.

Position mapping: the key in row r, column c has index k = r*18 + c. The eight positions in the last row, columns 10 to 17, are the modifiers. Every other position reports usage ID 4 + k.

Top module: `kbd_matrix_scan`

## Requirements
- R1: At most one row output is low at any time. Every row is driven low once in each scan, and all rows are high between scans.
- R2: A scan starts every SCAN_PERIOD clocks; row 0 goes low exactly SCAN_PERIOD clocks after it last went low.
- R3: The report is byte 0 = report_data[7:0] through byte 7 = report_data[63:56]. Byte 1 is always 0x00. Bytes 2 to 7 hold the usage IDs (4 + row*18 + col) of the pressed non-modifier keys in ascending index order, and unused slots are 0x00.
- R4: Modifier bit m of byte 0 (m = 0..7: left ctrl, left shift, left alt, left GUI, right ctrl, right shift, right alt, right GUI) reflects the key at row 7, column 10+m. These keys never occupy a key slot.
- R5: When more than six non-modifier keys are pressed, all six key slots read 0x01 while byte 0 still carries the modifiers.
- R6: A scan in which two rows share a pressed column and, across those two rows, some other column is also pressed is a ghost. It issues no report, and the previous report and pressed set are kept.
- R7: A report is issued only when the pressed set differs from the last accepted set; an unchanged scan leaves report_valid low.
- R8: report_valid stays high with the report unchanged until report_ack is high at a clock edge, after which it is low.
- R9: A changed scan overwrites an unacknowledged report and keeps report_valid high.
- R10: After reset all rows are high, report_valid is low and report_data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_drive_n | output | 8 | Row strobes, active low |
| col_in_n | input | 18 | Column sense lines, low = key closed on the driven row |
| report_data | output | 64 | Boot keyboard input report, byte 0 in bits 7:0 |
| report_valid | output | 1 | A new report is waiting |
| report_ack | input | 1 | Consumer has taken the report |

## Verification
Single keys in row 0 and in deeper rows check the position-to-usage arithmetic and the slot ordering. Modifier mixes, including two modifiers together with two letters, show that modifiers land in byte 0 and never in a slot. Six and seven simultaneous keys mark the boundary between normal packing and rollover. Three-corner and four-corner rectangles, followed by a non-ghost pair on the same rows, show that ghost scans are dropped without disturbing the held report. Unchanged scans, acknowledged and unacknowledged reports, and a full release separate the change-only, hold and overwrite rules.

// File: rtl/kbd_matrix_scan.sv
module kbd_matrix_scan #(
  parameter int ROWS        = 8,
  parameter int COLS        = 18,
  parameter int SLOTS       = 6,
  parameter int SETTLE      = 16,
  parameter int SCAN_PERIOD = 5_000_000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  output logic [ROWS-1:0]        row_drive_n,
  input  logic [COLS-1:0]        col_in_n,
  output logic [8*(SLOTS+2)-1:0] report_data,
  output logic                   report_valid,
  input  logic                   report_ack
);
  localparam int RPT_W    = 8 * (SLOTS + 2);
  localparam int MOD_COL0 = COLS - 8;
  localparam int RW       = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int SW       = (SETTLE > 1) ? $clog2(SETTLE + 1) : 1;
  localparam int TW       = $clog2(SCAN_PERIOD);

  logic [TW-1:0]                tick_cnt;
  logic                         busy;
  logic [RW-1:0]                row_idx;
  logic [SW-1:0]                settle_cnt;
  logic                         scan_done;
  logic [ROWS-1:0][COLS-1:0]    snap;
  logic [ROWS-1:0][COLS-1:0]    last_keys;
  logic [COLS-1:0]              common;
  logic                         ghost;
  logic [SLOTS-1:0][7:0]        slot_q;
  logic [7:0]                   mods;
  logic [RPT_W-1:0]             next_report;
  logic                         changed;

  assign row_drive_n = busy ? ~(ROWS'(1) << row_idx) : '1;
  assign changed     = (snap != last_keys);
  assign next_report = {slot_q, 8'h00, mods};

  always_comb begin
    ghost  = 1'b0;
    common = '0;
    for (int a = 0; a < ROWS; a++) begin
      for (int b = a + 1; b < ROWS; b++) begin
        common = snap[a] & snap[b];
        if (common != '0 &&
            (((snap[a] | snap[b]) != common) || ((common & (common - COLS'(1))) != '0)))
          ghost = 1'b1;
      end
    end
  end

  always_comb begin
    int n;
    n      = 0;
    mods   = '0;
    slot_q = '0;
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        if (snap[r][c]) begin
          if (r == ROWS - 1 && c >= MOD_COL0) begin
            mods[3'(c - MOD_COL0)] = 1'b1;
          end else begin
            for (int s = 0; s < SLOTS; s++)
              if (s == n) slot_q[s] = 8'(4 + r * COLS + c);
            n++;
          end
        end
      end
    end
    if (n > SLOTS)
      for (int s = 0; s < SLOTS; s++) slot_q[s] = 8'h01;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_cnt     <= '0;
      busy         <= 1'b0;
      row_idx      <= '0;
      settle_cnt   <= '0;
      scan_done    <= 1'b0;
      snap         <= '0;
      last_keys    <= '0;
      report_data  <= '0;
      report_valid <= 1'b0;
    end else begin
      scan_done <= 1'b0;
      if (tick_cnt == TW'(SCAN_PERIOD - 1)) tick_cnt <= '0;
      else tick_cnt <= tick_cnt + 1'b1;

      if (!busy) begin
        if (tick_cnt == TW'(SCAN_PERIOD - 1)) begin
          busy       <= 1'b1;
          row_idx    <= '0;
          settle_cnt <= '0;
        end
      end else if (settle_cnt == SW'(SETTLE - 1)) begin
        snap[row_idx] <= ~col_in_n;
        settle_cnt    <= '0;
        if (row_idx == RW'(ROWS - 1)) begin
          busy      <= 1'b0;
          scan_done <= 1'b1;
        end else begin
          row_idx <= row_idx + 1'b1;
        end
      end else begin
        settle_cnt <= settle_cnt + 1'b1;
      end

      if (scan_done && !ghost && changed) begin
        last_keys    <= snap;
        report_data  <= next_report;
        report_valid <= 1'b1;
      end else if (report_ack) begin
        report_valid <= 1'b0;
      end
    end
  end

  a_r1_one_row: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~row_drive_n) <= 1);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    report_valid && !report_ack |=> report_valid);

  a_r8_report_steady: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_done |=> $stable(report_data));

  a_r6_ghost_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done && ghost |=> $stable(report_data) && $stable(last_keys) && !$rose(report_valid));

  a_r7_change_only: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done && !changed |=> $stable(report_data) && !$rose(report_valid));
endmodule

// File: tb/kbd_matrix_scan_tb.sv
module kbd_matrix_scan_tb;
  localparam int PERIOD = 200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  row_drive_n;
  logic [17:0] col_in_n;
  logic [63:0] report_data;
  logic        report_valid;
  logic        report_ack = 1'b0;
  logic [7:0][17:0] keys = '0;
  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc++;

  always_comb begin
    for (int c = 0; c < 18; c++) begin
      col_in_n[c] = 1'b1;
      for (int r = 0; r < 8; r++)
        if (!row_drive_n[r] && keys[r][c]) col_in_n[c] = 1'b0;
    end
  end

  kbd_matrix_scan #(.SETTLE(3), .SCAN_PERIOD(PERIOD)) u_dut (
    .clk(clk), .rst_n(rst_n), .row_drive_n(row_drive_n), .col_in_n(col_in_n),
    .report_data(report_data), .report_valid(report_valid), .report_ack(report_ack));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sync_scan();
    while (row_drive_n == 8'hFF) @(negedge clk);
    while (row_drive_n != 8'hFF) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic apply(input logic [7:0][17:0] k);
    sync_scan();
    keys = k;
    sync_scan();
  endtask

  task automatic ack();
    report_ack = 1'b1;
    @(negedge clk);
    report_ack = 1'b0;
  endtask

  task automatic t_reset();
    check("R10 rows idle", {56'd0, row_drive_n}, 64'hFF);
    check("R10 valid", {63'd0, report_valid}, 64'd0);
    check("R10 report", report_data, 64'd0);
  endtask

  task automatic t_strobe();
    int bad = 0;
    logic [7:0] seen = '0;
    while (row_drive_n == 8'hFF) @(negedge clk);
    while (row_drive_n != 8'hFF) begin
      if ($countones(~row_drive_n) > 1) bad++;
      seen |= ~row_drive_n;
      @(negedge clk);
    end
    check("R1 single row low", 64'(bad), 64'd0);
    check("R1 every row driven", {56'd0, seen}, 64'hFF);
  endtask

  task automatic t_period();
    int t0;
    while (row_drive_n[0] !== 1'b0) @(negedge clk);
    t0 = cyc;
    while (row_drive_n[0] !== 1'b1) @(negedge clk);
    while (row_drive_n[0] !== 1'b0) @(negedge clk);
    check("R2 scan period", 64'(cyc - t0), 64'(PERIOD));
  endtask

  task automatic t_single();
    logic [7:0][17:0] k = '0;
    k[0][0] = 1'b1;
    apply(k);
    check("R3 single key", report_data, 64'h0000_0000_0004_0000);
    check("R8 valid set", {63'd0, report_valid}, 64'd1);
    repeat (5) @(negedge clk);
    check("R8 valid held", {63'd0, report_valid}, 64'd1);
    ack();
    check("R8 valid cleared", {63'd0, report_valid}, 64'd0);
    check("R8 report kept", report_data, 64'h0000_0000_0004_0000);
    apply(k);
    check("R7 unchanged no report", {63'd0, report_valid}, 64'd0);
  endtask

  task automatic t_mods();
    logic [7:0][17:0] k = '0;
    k[7][10] = 1'b1; k[0][0] = 1'b1;
    apply(k);
    check("R4 lctrl+A", report_data, 64'h0000_0000_0004_0001);
    k[7][16] = 1'b1; k[0][1] = 1'b1;
    apply(k);
    check("R4 lctrl+ralt+A+B", report_data, 64'h0000_0000_0504_0041);
    k = '0;
    k[7][17:10] = 8'hFF;
    apply(k);
    check("R4 all modifiers", report_data, 64'h0000_0000_0000_00FF);
    ack();
  endtask

  task automatic t_far();
    logic [7:0][17:0] k = '0;
    k[2][3] = 1'b1; k[7][8] = 1'b1;
    apply(k);
    check("R3 deep rows order", report_data, 64'h0000_0000_8A2B_0000);
    ack();
  endtask

  task automatic t_six_seven();
    logic [7:0][17:0] k = '0;
    k[0][5:0] = 6'h3F;
    apply(k);
    check("R3 six keys", report_data, 64'h0908_0706_0504_0000);
    k[0][6] = 1'b1; k[7][11] = 1'b1;
    apply(k);
    check("R5 rollover", report_data, 64'h0101_0101_0101_0002);
    ack();
  endtask

  task automatic t_ghost();
    logic [7:0][17:0] k = '0;
    k[0][0] = 1'b1;
    apply(k);
    ack();
    k = '0;
    k[1][2] = 1'b1; k[1][5] = 1'b1; k[3][2] = 1'b1;
    apply(k);
    check("R6 three-corner valid", {63'd0, report_valid}, 64'd0);
    check("R6 three-corner report", report_data, 64'h0000_0000_0004_0000);
    k = '0;
    k[2][1] = 1'b1; k[2][4] = 1'b1; k[4][1] = 1'b1; k[4][4] = 1'b1;
    apply(k);
    check("R6 four-corner valid", {63'd0, report_valid}, 64'd0);
    check("R6 four-corner report", report_data, 64'h0000_0000_0004_0000);
    k = '0;
    k[1][2] = 1'b1; k[1][5] = 1'b1;
    apply(k);
    check("R6 recovery report", report_data, 64'h0000_0000_1B18_0000);
    check("R6 recovery valid", {63'd0, report_valid}, 64'd1);
    ack();
  endtask

  task automatic t_overwrite();
    logic [7:0][17:0] k = '0;
    k[0][0] = 1'b1;
    apply(k);
    k = '0;
    k[0][1] = 1'b1;
    apply(k);
    check("R9 overwrite report", report_data, 64'h0000_0000_0005_0000);
    check("R9 overwrite valid", {63'd0, report_valid}, 64'd1);
    ack();
    apply('0);
    check("R7 release report", report_data, 64'd0);
    check("R7 release valid", {63'd0, report_valid}, 64'd1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_strobe();
    t_period();
    t_single();
    t_mods();
    t_far();
    t_six_seven();
    t_ghost();
    t_overwrite();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule